// File: doc/BRIEF.md
# I2C Register-Access Slave Port

This block is an I2C target that lets a bus master read and write a bank of byte-wide configuration registers. The SCL and SDA lines are sampled by the system clock. SDA is modelled as an input plus an active-high pull-low enable, which an external open-drain pad turns into the wired line. Every register access goes through an 8-bit pointer that steps forward by one after each data byte.

The 7-bit bus address is a fixed upper nibble followed by three strap inputs. After the address byte of a write, the first byte always loads the pointer, and each later byte is written to the register it names. A read cannot load the pointer. A master therefore sends a short write that carries only the pointer, ends it with STOP or a repeated START, and then reads the registers that follow from that point.

The register side has a combinational read: `reg_rdata` must reflect `reg_addr` in the same clock cycle in which `reg_re` is high. Clock stretching, general call and 10-bit addressing are not provided.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, `sda_oe`, `reg_we` and `reg_re` are low and `reg_addr` is 0x00.
- R2: A START (SDA falling while SCL is high) begins address reception. When the first 8 bits, MSB first, carry the 7-bit address {ADDR_HI, strap_i[2:0]} followed by the R/W bit (1 = read), the slave pulls SDA low during the ninth SCL pulse.
- R3: When the address does not match, the slave leaves SDA released and raises neither strobe until the next START.
- R4: In a write, the slave loads the byte after the address into the pointer and acknowledges it.
- R5: Each further write byte is acknowledged. It produces one single-cycle `reg_we` pulse with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte, taken MSB first. The pointer then increments and wraps from 0xFF to 0x00.
- R6: In a read, the slave raises `reg_re` for one cycle with `reg_addr` equal to the pointer and captures `reg_rdata` in that cycle. It shifts the captured byte out MSB first, and the pointer increments.
- R7: When the master acknowledges a transmitted byte (SDA low on the ninth pulse), the slave sends the next register. When the master does not acknowledge, the slave releases SDA and raises no further `reg_re` until a START.
- R8: The pointer survives a STOP and a repeated START. A write ended right after the pointer byte sets the start address of a following read.
- R9: The slave begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | Pull SDA low when high |
| strap_i | input | 3 | Low three bits of the bus address |
| reg_addr | output | 8 | Register address (current pointer) |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register read data, valid in the cycle of reg_re |
| reg_re | output | 1 | One-cycle read strobe |

## Verification
Each kind of wrong internal state shows up at a different point on the ports:
- A wrong bit count or a mis-decoded address shows within one byte time, as a missing or misplaced acknowledge on SDA.
- A pointer that is loaded or advanced wrongly stays hidden until the next data byte. It then shows as a wrong `reg_addr` on the write strobe, or as a wrong byte shifted out on a read. Reading after an aborted write, and writing across the 0xFF boundary, expose it.
- A read state that survives a master NACK shows within one SCL period, as extra read strobes or as SDA being pulled low while the master expects the line idle.

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter logic [3:0] ADDR_HI = 4'b0010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_i,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata,
  output logic       reg_re
);

  typedef enum logic [2:0] {S_IDLE, S_RECV, S_ACK, S_SEND, S_MACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_t;

  logic [2:0] scl_q, sda_q;
  st_t        st;
  kind_t      kind;
  logic [7:0] sh, ptr;
  logic [2:0] cnt;
  logic       full, rd, mnack;

  wire scl_s = scl_q[1];
  wire scl_p = scl_q[2];
  wire sda_s = sda_q[1];
  wire sda_p = sda_q[2];
  wire scl_rise = scl_s & ~scl_p;
  wire scl_fall = ~scl_s & scl_p;
  wire start_c  = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_c   = scl_s & scl_p & ~sda_p & sda_s;

  assign reg_re = scl_fall & ((st == S_ACK && kind == K_ADDR && rd) ||
                              (st == S_MACK && !mnack));
  assign sda_oe   = (st == S_ACK) || (st == S_SEND && !sh[7]);
  assign reg_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      kind      <= K_ADDR;
      sh        <= 8'hFF;
      ptr       <= 8'h00;
      cnt       <= 3'd0;
      full      <= 1'b0;
      rd        <= 1'b0;
      mnack     <= 1'b0;
      reg_we    <= 1'b0;
      reg_wdata <= 8'h00;
    end else begin
      reg_we <= 1'b0;
      if (start_c) begin
        st   <= S_RECV;
        kind <= K_ADDR;
        cnt  <= 3'd0;
        full <= 1'b0;
        sh   <= 8'hFF;
      end else if (stop_c) begin
        st <= S_IDLE;
        sh <= 8'hFF;
      end else begin
        case (st)
          S_RECV:
            if (scl_rise) begin
              sh   <= {sh[6:0], sda_s};
              cnt  <= cnt + 3'd1;
              full <= (cnt == 3'd7);
            end else if (scl_fall && full) begin
              full <= 1'b0;
              cnt  <= 3'd0;
              case (kind)
                K_ADDR:
                  if (sh[7:1] == {ADDR_HI, strap_i}) begin
                    rd <= sh[0];
                    st <= S_ACK;
                  end else begin
                    st <= S_IDLE;
                  end
                K_PTR: begin
                  ptr <= sh;
                  st  <= S_ACK;
                end
                default: begin
                  reg_we    <= 1'b1;
                  reg_wdata <= sh;
                  st        <= S_ACK;
                end
              endcase
            end
          S_ACK:
            if (scl_fall) begin
              if (kind == K_ADDR && rd) begin
                st   <= S_SEND;
                sh   <= reg_rdata;
                ptr  <= ptr + 8'd1;
                cnt  <= 3'd0;
                kind <= K_DATA;
              end else begin
                st <= S_RECV;
                if (kind == K_DATA) ptr <= ptr + 8'd1;
                kind <= (kind == K_ADDR) ? K_PTR : K_DATA;
              end
            end
          S_SEND:
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                st <= S_MACK;
                sh <= 8'hFF;
              end else begin
                sh  <= {sh[6:0], 1'b1};
                cnt <= cnt + 3'd1;
              end
            end
          S_MACK:
            if (scl_rise) begin
              mnack <= sda_s;
            end else if (scl_fall) begin
              if (mnack) begin
                st <= S_IDLE;
              end else begin
                st  <= S_SEND;
                sh  <= reg_rdata;
                ptr <= ptr + 8'd1;
                cnt <= 3'd0;
              end
            end
          default: ;
        endcase
      end
    end
  end

  a_r5_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  a_r6_re_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q[1]);
  a_r6_re_starts_send: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> st == S_SEND);
  a_r5_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
  a_r8_ptr_held_on_we: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> $stable(reg_addr));

endmodule

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
  localparam int CLK_NS = 10;
  localparam int Q = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we, reg_re;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [2:0] strap = 3'b101;
  logic [7:0] rf [256];
  logic [15:0] exp_q [$];
  int n_chk = 0, n_bad = 0, re_cnt = 0, r9_viol = 0;
  logic prev_oe = 1'b0, prev_scl = 1'b1;
  bit done = 1'b0;

  wire sda_line = sda_m & ~sda_oe;

  always #(CLK_NS/2) clk = ~clk;

  i2c_reg_slave i_i2c_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_i(strap), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .reg_re(reg_re));

  assign reg_rdata = rf[reg_addr];

  initial for (int i = 0; i < 256; i++) rf[i] = 8'(i) ^ 8'h5A;
  always @(posedge clk) if (reg_we) rf[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (reg_we) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 R5 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({reg_addr, reg_wdata} == e, "R5 write addr/data", {reg_addr, reg_wdata}, e);
      end
    end
    if (reg_re) re_cnt++;
    if (rst_n && scl_m && prev_scl && sda_oe && !prev_oe) r9_viol++;
    prev_oe = sda_oe;
    prev_scl = scl_m;
  end

  task automatic wq(); repeat (Q) @(posedge clk); endtask
  task automatic i2c_start(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic i2c_stop(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); endtask
  task automatic wbit(input logic b); sda_m = b; wq(); scl_m = 1; wq(); scl_m = 0; wq(); endtask
  task automatic rbit(output logic b);
    sda_m = 1; wq(); scl_m = 1; repeat (Q/2) @(posedge clk);
    @(negedge clk) b = sda_line;
    repeat (Q/2) @(posedge clk); scl_m = 0; wq();
  endtask
  task automatic send(input logic [7:0] v, output bit ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(a); ack = !a;
  endtask
  task automatic recv(output logic [7:0] v, input bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
    wbit(!ack);
  endtask
  task automatic push_w(input logic [7:0] a, input logic [7:0] d); exp_q.push_back({a, d}); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    int re0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!sda_oe && !reg_we && !reg_re, "R1 strobes idle", {sda_oe, reg_we, reg_re}, 0);
    chk(reg_addr == 8'h00, "R1 pointer reset", reg_addr, 0);
    rst_n = 1;
    repeat (10) @(posedge clk);

    // write two bytes from 0x10
    i2c_start();
    send(8'h2A, ack); chk(ack, "R2 address ack", ack, 1);
    send(8'h10, ack); chk(ack, "R4 pointer ack", ack, 1);
    push_w(8'h10, 8'hA5); send(8'hA5, ack); chk(ack, "R5 data ack", ack, 1);
    push_w(8'h11, 8'h3C); send(8'h3C, ack); chk(ack, "R5 data ack 2", ack, 1);
    i2c_stop();

    // wrong address
    re0 = re_cnt;
    i2c_start();
    send(8'h2C, ack); chk(!ack, "R3 no ack on mismatch", ack, 0);
    send(8'h00, ack); chk(!ack, "R3 ignored byte not acked", ack, 0);
    i2c_stop();
    chk(re_cnt == re0, "R3 no read strobe", re_cnt - re0, 0);

    // pointer-only write, stop, then read
    i2c_start(); send(8'h2A, ack); send(8'h10, ack); i2c_stop();
    re0 = re_cnt;
    i2c_start();
    send(8'h2B, ack); chk(ack, "R2 read address ack", ack, 1);
    recv(v, 1); chk(v == 8'hA5, "R8 read after aborted write", v, 8'hA5);
    recv(v, 0); chk(v == 8'h3C, "R7 next register after ack", v, 8'h3C);
    chk(re_cnt - re0 == 2, "R6 one strobe per byte", re_cnt - re0, 2);
    recv(v, 0); chk(v == 8'hFF, "R7 released after nack", v, 8'hFF);
    chk(re_cnt - re0 == 2, "R7 no strobe after nack", re_cnt - re0, 2);
    i2c_stop();

    // wrap across 0xFF
    i2c_start(); send(8'h2A, ack); send(8'hFF, ack);
    push_w(8'hFF, 8'h11); send(8'h11, ack);
    push_w(8'h00, 8'h22); send(8'h22, ack); chk(ack, "R5 ack after wrap", ack, 1);
    i2c_stop();

    // write then repeated start read continues from pointer
    i2c_start(); send(8'h2A, ack); send(8'h40, ack);
    push_w(8'h40, 8'h77); send(8'h77, ack);
    i2c_start();
    send(8'h2B, ack); chk(ack, "R8 read after repeated start", ack, 1);
    recv(v, 1); chk(v == 8'h1B, "R6 MSB-first read at pointer", v, 8'h1B);
    recv(v, 0); chk(v == 8'h18, "R6 pointer increments on read", v, 8'h18);
    i2c_stop();

    // read from 0xFF after repeated start keeps pointer
    i2c_start(); send(8'h2A, ack); send(8'hFF, ack);
    i2c_start(); send(8'h2B, ack);
    recv(v, 1); chk(v == 8'h11, "R8 pointer kept over repeated start", v, 8'h11);
    recv(v, 0); chk(v == 8'h22, "R6 read wraps to 0x00", v, 8'h22);
    i2c_stop();

    repeat (20) @(posedge clk);
    chk(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
    chk(r9_viol == 0, "R9 pull starts with SCL low", r9_viol, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule